// File: doc/BRIEF.md
# I2C-Controlled One-Hot Channel Selector

This block is an I2C target with a single control register. The register decides which one of eight downstream bus channels is tied to the upstream bus. The block runs on a fast system clock and oversamples the upstream SCL and SDA lines. It acknowledges its own address, accepts write data, and returns the register on reads. When it talks on SDA, it asserts an open-drain pull-down enable.

The block drives an eight-bit enable vector toward the pass gates. At most one bit of that vector is ever high. A new selection written over the bus does not take effect until the STOP condition that closes the transaction. This keeps the connected channel fixed while the transaction is still running.

The block has an active-low recovery input that returns it to channel 0. A controller uses this when a downstream bus is stuck low: channel 0 is reconnected and the protocol state is cleared. Three strap pins set the low bits of the target address, so eight of these blocks can share one upstream bus.

Top module: `i2c_chan_sel`

## Requirements
- R1: After the synchronous reset `rst`, `chan_en` is 8'b0000_0001, `sda_pd` is low, and the control register holds 8'h08.
- R2: `chan_en` never has more than one bit set.
- R3: Control register encoding: bit 3 is the enable flag and bits 2:0 are the channel number. With bit 3 set, `chan_en` equals 1 shifted left by the channel number. With bit 3 clear, `chan_en` is all zeros. Bits 7:4 are not stored and always read back as 0.
- R4: The 7-bit target address is 4'b1110 in the upper bits followed by `addr_sel[2:0]`. The eighth bit of the address byte is 0 for a write and 1 for a read. A matching address is acknowledged by holding `sda_pd` high during the ninth SCL pulse. `sda_pd` only changes after an SCL falling edge, a START, a STOP, or a reset.
- R5: A non-matching address gets no acknowledge. The bytes that follow it in that transaction get no acknowledge either, and they leave the register unchanged.
- R6: Every data byte in a write is acknowledged. The last byte written becomes the new register value only at the STOP that ends the transaction, so `chan_en` is unchanged until that STOP.
- R7: A read returns the current register value, most significant bit first.
- R8: While `rec_n` is low, the block takes this state on the next clock: channel 0 only enabled, `sda_pd` released, protocol state idle, register 8'h08, and any pending write discarded.
- R9: START and STOP are recognised as SDA changing while SCL is high. Correct behaviour does not depend on the SCL period: the block works for any number of system clocks per SCL phase above the synchronizer latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for oversampling |
| rst | input | 1 | Synchronous active-high reset |
| rec_n | input | 1 | Active-low bus recovery input, sampled on clk |
| scl_in | input | 1 | Upstream SCL line level |
| sda_in | input | 1 | Upstream SDA line level |
| addr_sel | input | 3 | Address strap pins, low three address bits |
| sda_pd | output | 1 | Open-drain pull-down enable for SDA |
| chan_en | output | 8 | One-hot downstream channel enables |

## Verification
The bench checks that `chan_en` holds its old value between the acknowledged data byte and the STOP. A design that applied the write at once would switch channels in the middle of a transaction. It also pulls `rec_n` low while a write is pending, then issues a STOP. A design that kept the pending byte would reconnect the wrong channel at that STOP instead of staying on channel 0.

The bench writes a byte with the enable flag clear and junk in the upper bits. This catches a decode that ignores bit 3, and register storage that echoes bits 7:4 on read-back. A wrong strap address is sent to catch a design that acknowledges every address. A second transaction with a long SCL period catches edge detection that only works at one fixed clock ratio.

// File: rtl/i2c_sel_pkg.sv
package i2c_sel_pkg;

    localparam int NCH       = 8;
    localparam int CH_W      = $clog2(NCH);
    localparam int BYTE_W    = 8;
    localparam int CNT_W     = $clog2(BYTE_W) + 1;
    localparam logic [3:0]        ADDR_PREFIX = 4'b1110;
    localparam logic [BYTE_W-1:0] CTRL_RESET  = 8'h08;
    localparam logic [BYTE_W-1:0] CTRL_MASK   = 8'h0F;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WDAT,
        ST_WACK,
        ST_RDAT,
        ST_RACK
    } sel_state_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    function automatic logic [NCH-1:0] chan_decode(input logic [CH_W:0] ctrl);
        logic [NCH-1:0] v;
        v = '0;
        if (ctrl[CH_W]) v[ctrl[CH_W-1:0]] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/i2c_sel_sync.sv
module i2c_sel_sync
    import i2c_sel_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output bus_evt_t evt
);

    logic [1:0] pipe [STAGES];
    logic [1:0] prev;
    logic [1:0] cur;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= 2'b11;
                else     pipe[g] <= {scl_raw, sda_raw};
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) pipe[g] <= 2'b11;
                else     pipe[g] <= pipe[g-1];
            end
        end
    end

    assign cur = pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) prev <= 2'b11;
        else     prev <= cur;
    end

    always_comb begin
        evt.sda      = cur[0];
        evt.scl_rise = cur[1] & ~prev[1];
        evt.scl_fall = ~cur[1] & prev[1];
        evt.start    = cur[1] & prev[1] & prev[0] & ~cur[0];
        evt.stop     = cur[1] & prev[1] & ~prev[0] & cur[0];
    end

endmodule

// File: rtl/i2c_sel_target.sv
module i2c_sel_target
    import i2c_sel_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_evt_t          evt,
    input  logic [2:0]        addr_sel,
    input  logic [BYTE_W-1:0] rd_val,
    output logic              sda_pd,
    output logic              wr_stb,
    output logic [BYTE_W-1:0] wr_val
);

    sel_state_t        st;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sr;
    logic [BYTE_W-1:0] tx;
    logic [BYTE_W-1:0] pend;
    logic              pend_v;
    logic              rw;
    logic              nack;
    logic              byte_done;

    assign byte_done = evt.scl_fall && (cnt == CNT_W'(BYTE_W));

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sr     <= '0;
            tx     <= '0;
            pend   <= '0;
            pend_v <= 1'b0;
            rw     <= 1'b0;
            nack   <= 1'b0;
            sda_pd <= 1'b0;
            wr_stb <= 1'b0;
            wr_val <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (evt.stop) begin
                st     <= ST_IDLE;
                sda_pd <= 1'b0;
                if (pend_v) begin
                    wr_stb <= 1'b1;
                    wr_val <= pend;
                    pend_v <= 1'b0;
                end
            end else if (evt.start) begin
                st     <= ST_ADDR;
                cnt    <= '0;
                sda_pd <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR: begin
                        if (evt.scl_rise) begin
                            sr  <= {sr[BYTE_W-2:0], evt.sda};
                            cnt <= cnt + 1'b1;
                        end else if (byte_done) begin
                            if (sr[7:1] == {ADDR_PREFIX, addr_sel}) begin
                                st     <= ST_AACK;
                                sda_pd <= 1'b1;
                                rw     <= sr[0];
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (evt.scl_fall) begin
                            cnt <= '0;
                            if (rw) begin
                                st     <= ST_RDAT;
                                tx     <= rd_val;
                                sda_pd <= ~rd_val[BYTE_W-1];
                            end else begin
                                st     <= ST_WDAT;
                                sda_pd <= 1'b0;
                            end
                        end
                    end
                    ST_WDAT: begin
                        if (evt.scl_rise) begin
                            sr  <= {sr[BYTE_W-2:0], evt.sda};
                            cnt <= cnt + 1'b1;
                        end else if (byte_done) begin
                            st     <= ST_WACK;
                            sda_pd <= 1'b1;
                            pend   <= sr;
                            pend_v <= 1'b1;
                        end
                    end
                    ST_WACK: begin
                        if (evt.scl_fall) begin
                            st     <= ST_WDAT;
                            cnt    <= '0;
                            sda_pd <= 1'b0;
                        end
                    end
                    ST_RDAT: begin
                        if (evt.scl_fall) begin
                            if (cnt == CNT_W'(BYTE_W - 1)) begin
                                st     <= ST_RACK;
                                sda_pd <= 1'b0;
                            end else begin
                                sda_pd <= ~tx[BYTE_W-2];
                                tx     <= {tx[BYTE_W-2:0], 1'b0};
                                cnt    <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (evt.scl_rise) begin
                            nack <= evt.sda;
                        end else if (evt.scl_fall) begin
                            if (nack) begin
                                st <= ST_IDLE;
                            end else begin
                                st     <= ST_RDAT;
                                cnt    <= '0;
                                tx     <= rd_val;
                                sda_pd <= ~rd_val[BYTE_W-1];
                            end
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/i2c_chan_sel.sv
module i2c_chan_sel
    import i2c_sel_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           rec_n,
    input  logic           scl_in,
    input  logic           sda_in,
    input  logic [2:0]     addr_sel,
    output logic           sda_pd,
    output logic [NCH-1:0] chan_en
);

    logic              rst_all;
    bus_evt_t          evt;
    logic              wr_stb;
    logic [BYTE_W-1:0] wr_val;
    logic [BYTE_W-1:0] ctrl;

    assign rst_all = rst | ~rec_n;

    i2c_sel_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst_all),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .evt     (evt)
    );

    i2c_sel_target u_tgt (
        .clk      (clk),
        .rst      (rst_all),
        .evt      (evt),
        .addr_sel (addr_sel),
        .rd_val   (ctrl),
        .sda_pd   (sda_pd),
        .wr_stb   (wr_stb),
        .wr_val   (wr_val)
    );

    always_ff @(posedge clk) begin
        if (rst_all)     ctrl <= CTRL_RESET;
        else if (wr_stb) ctrl <= wr_val & CTRL_MASK;
    end

    assign chan_en = chan_decode(ctrl[CH_W:0]);

endmodule

// File: rtl/i2c_sel_checker.sv
module i2c_sel_checker
    import i2c_sel_pkg::*;
(
    input logic           clk,
    input logic           rst,
    input logic           rec_n,
    input logic           sda_pd,
    input logic [NCH-1:0] chan_en,
    input logic           wr_stb,
    input logic           scl_fall,
    input logic           start,
    input logic           stop
);

    assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(chan_en));

    assert_apply_on_stop_R6: assert property (@(posedge clk) disable iff (rst || !rec_n)
        (chan_en != $past(chan_en)) |-> ($past(wr_stb) || $past(!rec_n) || $past(rst)));

    assert_recover_R8: assert property (@(posedge clk) disable iff (rst)
        !rec_n |=> (chan_en == NCH'(1) && !sda_pd));

    assert_sda_after_fall_R4: assert property (@(posedge clk) disable iff (rst || !rec_n)
        (sda_pd != $past(sda_pd)) |->
            ($past(scl_fall) || $past(start) || $past(stop) || $past(!rec_n) || $past(rst)));

endmodule

bind i2c_chan_sel i2c_sel_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .rec_n    (rec_n),
    .sda_pd   (sda_pd),
    .chan_en  (chan_en),
    .wr_stb   (wr_stb),
    .scl_fall (evt.scl_fall),
    .start    (evt.start),
    .stop     (evt.stop)
);

// File: tb/sim_i2c_chan_sel.sv
module sim_i2c_chan_sel;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rec_n = 1'b1;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic [2:0] addr_sel = 3'b101;
    logic       sda_pd;
    logic [7:0] chan_en;
    logic       sda_line;
    int         q = 20;
    int         vectors = 0;
    int         miscompares = 0;

    assign sda_line = sda_h & ~sda_pd;

    always #5 clk = ~clk;

    i2c_chan_sel u0 (
        .clk      (clk),
        .rst      (rst),
        .rec_n    (rec_n),
        .scl_in   (scl_h),
        .sda_in   (sda_line),
        .addr_sel (addr_sel),
        .sda_pd   (sda_pd),
        .chan_en  (chan_en)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_h = 1'b1; scl_h = 1'b1; tick(q);
        sda_h = 1'b0; tick(q);
        scl_h = 1'b0; tick(q);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(q);
        scl_h = 1'b1; tick(q);
        sda_h = 1'b1; tick(q);
    endtask

    task automatic send_bit(input logic b);
        sda_h = b; tick(q);
        scl_h = 1'b1; tick(2 * q);
        scl_h = 1'b0; tick(q);
    endtask

    task automatic recv_bit(output logic b);
        sda_h = 1'b1; tick(q);
        scl_h = 1'b1; tick(q);
        b = sda_line; tick(q);
        scl_h = 1'b0; tick(q);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic nb;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(nb);
        ack = ~nb;
    endtask

    task automatic read_byte(input logic ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            recv_bit(b);
            d[i] = b;
        end
        send_bit(~ack);
    endtask

    function automatic logic [7:0] abyte(input logic [2:0] a, input logic rd);
        return {4'b1110, a, rd};
    endfunction

    task automatic do_write(input logic [7:0] d);
        logic ack;
        bus_start();
        write_byte(abyte(addr_sel, 1'b0), ack);
        write_byte(d, ack);
        bus_stop();
        tick(10);
    endtask

    task automatic t_reset();
        check("R1 chan_en after reset", chan_en, 8'h01);
        check("R1 sda_pd after reset", sda_pd, 1'b0);
    endtask

    task automatic t_write_on_stop();
        logic ack;
        bus_start();
        write_byte(abyte(3'b101, 1'b0), ack);
        check("R4 address ack", ack, 1'b1);
        write_byte(8'h0B, ack);
        check("R6 data ack", ack, 1'b1);
        tick(10);
        check("R6 chan_en held before STOP", chan_en, 8'h01);
        bus_stop();
        tick(10);
        check("R6 chan_en after STOP ch3", chan_en, 8'h08);
    endtask

    task automatic t_read();
        logic ack;
        logic [7:0] d;
        bus_start();
        write_byte(abyte(3'b101, 1'b1), ack);
        check("R4 read address ack", ack, 1'b1);
        read_byte(1'b0, d);
        check("R7 read value", d, 8'h0B);
        bus_stop();
        tick(10);
        check("R7 read leaves chan_en", chan_en, 8'h08);
    endtask

    task automatic t_wrong_addr();
        logic ack;
        bus_start();
        write_byte(abyte(3'b010, 1'b0), ack);
        check("R5 wrong address nack", ack, 1'b0);
        write_byte(8'h0F, ack);
        check("R5 data after wrong address nack", ack, 1'b0);
        bus_stop();
        tick(10);
        check("R5 chan_en unchanged", chan_en, 8'h08);
    endtask

    task automatic t_encoding();
        logic ack;
        logic [7:0] d;
        do_write(8'hF7);
        check("R3 enable clear gives all off", chan_en, 8'h00);
        bus_start();
        write_byte(abyte(addr_sel, 1'b1), ack);
        read_byte(1'b0, d);
        bus_stop();
        tick(10);
        check("R3 upper bits read as zero", d, 8'h07);
        do_write(8'h0F);
        check("R3 channel 7 enable", chan_en, 8'h80);
        check("R2 single enable", $countones(chan_en), 1);
    endtask

    task automatic t_multi_byte();
        logic ack;
        bus_start();
        write_byte(abyte(addr_sel, 1'b0), ack);
        write_byte(8'h09, ack);
        write_byte(8'h0C, ack);
        check("R6 second data byte ack", ack, 1'b1);
        tick(10);
        check("R6 no change mid transaction", chan_en, 8'h80);
        bus_stop();
        tick(10);
        check("R6 last byte applied ch4", chan_en, 8'h10);
    endtask

    task automatic t_recover();
        logic ack;
        logic [7:0] d;
        bus_start();
        write_byte(abyte(addr_sel, 1'b0), ack);
        write_byte(8'h0E, ack);
        rec_n = 1'b0; tick(5);
        check("R8 chan_en during recovery", chan_en, 8'h01);
        check("R8 sda_pd released", sda_pd, 1'b0);
        rec_n = 1'b1; tick(5);
        bus_stop();
        tick(10);
        check("R8 pending write discarded", chan_en, 8'h01);
        bus_start();
        write_byte(abyte(addr_sel, 1'b1), ack);
        read_byte(1'b0, d);
        bus_stop();
        tick(10);
        check("R8 register back to 08", d, 8'h08);
    endtask

    task automatic t_slow_clock();
        logic ack;
        q = 300;
        addr_sel = 3'b010;
        tick(5);
        bus_start();
        write_byte(abyte(3'b010, 1'b0), ack);
        check("R9 slow SCL address ack", ack, 1'b1);
        write_byte(8'h0D, ack);
        check("R9 slow SCL data ack", ack, 1'b1);
        bus_stop();
        tick(10);
        check("R9 slow SCL ch5 applied", chan_en, 8'h20);
        q = 20;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        tick(5);
        rst = 1'b0;
        tick(5);
        t_reset();
        t_write_on_stop();
        t_read();
        t_wrong_addr();
        t_encoding();
        t_multi_byte();
        t_recover();
        t_slow_clock();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule